// File: doc/BRIEF.md
# Two-Level Decoded Byte Memory with Banked ROM and Nibble-Paired RAM

This block is a byte-wide memory on a 16-bit address bus. It holds a read-only region of 8 KB at the bottom of the address map, built from four 2K×8 banks stacked one after another. Above it sits a RAM region made of 1K-byte groups. Each group pairs two 1K×4 chips: one chip stores the low nibble and the other stores the high nibble. The block drives an active-low select for every ROM bank and every RAM group. It returns read data from whichever of them is addressed, and it flags accesses that hit nothing or try to write the ROM.

Selection is done in two stages. The first stage is a 3-to-8 decoder with active-low outputs. It takes address bits 13..11 and is enabled only when bits 15 and 14 are both zero. Its first four outputs select the ROM banks directly. Each RAM group select combines one of the upper decoder outputs with the level of address bit 10 through an active-low AND, meaning the output is low only when both inputs are low. The parameter `RAM_GROUPS` picks the 4 KB RAM layout (4 groups) or the 8 KB layout (8 groups, using decoder outputs 6 and 7 as well).

ROM contents are fixed at elaboration by a function of the address. RAM cells are plain behavioural storage. Read data and the error flag are registered: both appear one clock after the strobe.

Top module: `banked_mem_sys`

## Requirements
- R1: For an address in 0000H–1FFFH, exactly one bit of `romCsN` is low: bit k, where k is the value of address bits 12..11.
- R2: A read at a ROM address `a` returns the byte `a[7:0] XOR {3'b000, a[12:8]}`.
- R3: For an address in 2000H up to the top of RAM, exactly one bit of `ramCsN` is low: bit g, with g = (address − 2000H) / 400H. Group g is formed from decoder output 4 + g/2 together with address bit 10 equal to g mod 2.
- R4: A write to a RAM address stores the whole byte on that edge. Bits 3..0 go to one chip and bits 7..4 to the other, both updated together. A later read of that address returns the byte, and a RAM write does not raise `busErr`.
- R5: After reset, `readData` is 00H and `busErr` is 0. `readData` changes only on an edge where `rdStrobe` is high, and then shows the addressed byte from the next clock on. It holds its value through idle cycles and write-only cycles.
- R6: When address bits 15 or 14 are set, or the address lies above the populated RAM, all selects are high. A read of such an address returns 00H, and `busErr` is high in the cycle after any strobe to it.
- R7: A write to a ROM address changes nothing, and `busErr` is high in the following cycle. A later read of that address still returns the R2 byte.
- R8: At no time is more than one of the ROM and RAM selects low.
- R9: With `RAM_GROUPS` = 8, RAM covers 2000H–3FFFH. Addresses 3000H–3FFFH then store and return bytes without error, and group 7 is selected at 3C00H–3FFFH.
- R10: When `rdStrobe` and `wrStrobe` are both high at one RAM address, the read returns the contents held before that edge, and the new byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Byte address |
| wrData | input | 8 | Byte to write |
| rdStrobe | input | 1 | Read request for this cycle |
| wrStrobe | input | 1 | Write request for this cycle |
| readData | output | 8 | Registered read byte |
| busErr | output | 1 | Registered flag for an unmapped access or a ROM write |
| romCsN | output | 4 | Active-low ROM bank selects |
| ramCsN | output | RAM_GROUPS | Active-low RAM group selects |

## Verification
The decode is exercised with addresses at both ends of every ROM bank and RAM group. These expose any bank offset error or any mix-up in the level of address bit 10 within a group pair. RAM is written with bytes whose two nibbles differ, such as A5H, 3CH and F0H, so that swapped or stale nibble chips show up on read-back. Addresses with the high bits set and the unpopulated 3000H block check that the decoder's enable gates every select and that such reads return zero with an error. ROM writes, idle cycles and combined read-and-write cycles separate real updates from holds. A second instance with eight RAM groups shows that the upper block becomes usable storage there.

// File: rtl/memsys_pkg.sv
package memsys_pkg;

  // strobes handed from the select decoder to the storage datapath
  typedef struct packed {
    logic rdEn;     // latch a new read byte on this edge
    logic ramWrEn;  // write the selected RAM group on this edge
    logic errNow;   // this access is unmapped or writes ROM
  } memStrobe_t;

  // fixed ROM contents, a function of the byte address
  function automatic logic [7:0] romPattern(input logic [15:0] a);
    return a[7:0] ^ {3'b000, a[12:8]};
  endfunction

endpackage

// File: rtl/memsys_decode.sv
module memsys_decode
  import memsys_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ROM_AW     = 11,
  parameter int ROM_BANKS  = 4,
  parameter int RAM_GROUPS = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  rdStrobe,
  input  logic                  wrStrobe,
  output logic [ROM_BANKS-1:0]  romCsN,
  output logic [RAM_GROUPS-1:0] ramCsN,
  output memStrobe_t            strobes
);

  localparam int SEL_BITS = 3;
  localparam int SEL_LO   = ROM_AW;
  localparam int SEL_HI   = ROM_AW + SEL_BITS - 1;
  localparam int OUTS     = 1 << SEL_BITS;
  localparam int RAM_A10  = ROM_AW - 1;

  logic            decOffN;
  logic [OUTS-1:0] stageN;
  logic            anyRom;
  logic            anyRam;

  // stage one: 3-to-8 decoder with active-low outputs, gated by the high bits
  assign decOffN = |addr[ADDR_W-1:SEL_HI+1];

  always_comb begin
    stageN = '1;
    if (!decOffN) stageN[addr[SEL_HI:SEL_LO]] = 1'b0;
  end

  for (genvar b = 0; b < ROM_BANKS; b++) begin : g_rom
    assign romCsN[b] = stageN[b];
  end

  // stage two: active-low AND of a stage-one output and the bit-10 level
  for (genvar g = 0; g < RAM_GROUPS; g++) begin : g_ram
    logic lvlN;
    if (g % 2 == 0) begin : g_even
      assign lvlN = addr[RAM_A10];
    end else begin : g_odd
      assign lvlN = ~addr[RAM_A10];
    end
    assign ramCsN[g] = stageN[ROM_BANKS + g/2] | lvlN;
  end

  assign anyRom = ~&romCsN;
  assign anyRam = ~&ramCsN;

  always_comb begin
    strobes.rdEn    = rdStrobe;
    strobes.ramWrEn = wrStrobe & anyRam;
    strobes.errNow  = (rdStrobe | wrStrobe) &
                      (~(anyRom | anyRam) | (wrStrobe & anyRom));
  end

endmodule

// File: rtl/memsys_store.sv
module memsys_store
  import memsys_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RAM_AW     = 10,
  parameter int ROM_BANKS  = 4,
  parameter int RAM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ROM_BANKS-1:0]  romCsN,
  input  logic [RAM_GROUPS-1:0] ramCsN,
  input  memStrobe_t            strobes,
  output logic [DATA_W-1:0]     readData,
  output logic                  busErr
);

  localparam int NIB    = 4;
  localparam int CHIPS  = DATA_W / NIB;
  localparam int DEPTH  = 1 << RAM_AW;

  logic [RAM_GROUPS-1:0][DATA_W-1:0] grpByte;
  logic [DATA_W-1:0]                 selByte;

  // each group: nibble-wide chips side by side, sharing select and address
  for (genvar g = 0; g < RAM_GROUPS; g++) begin : g_grp
    for (genvar c = 0; c < CHIPS; c++) begin : g_chip
      logic [NIB-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
        if (strobes.ramWrEn && !ramCsN[g])
          cells[addr[RAM_AW-1:0]] <= wrData[c*NIB +: NIB];
      end
      assign grpByte[g][c*NIB +: NIB] = cells[addr[RAM_AW-1:0]];
    end
  end

  always_comb begin
    selByte = '0;
    if (~&romCsN) selByte = romPattern(addr);
    for (int g = 0; g < RAM_GROUPS; g++) begin
      if (!ramCsN[g]) selByte = grpByte[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readData <= '0;
      busErr   <= 1'b0;
    end else begin
      busErr <= strobes.errNow;
      if (strobes.rdEn) readData <= selByte;
    end
  end

  // R5: the read byte moves only after a read strobe
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> $stable(readData));

  // R4: a RAM-only write is never flagged
  a_r4_ram_write_clean: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ramWrEn && !strobes.rdEn) |=> !busErr);

endmodule

// File: rtl/banked_mem_sys.sv
module banked_mem_sys
  import memsys_pkg::*;
#(
  parameter int RAM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:0]           addr,
  input  logic [7:0]            wrData,
  input  logic                  rdStrobe,
  input  logic                  wrStrobe,
  output logic [7:0]            readData,
  output logic                  busErr,
  output logic [3:0]            romCsN,
  output logic [RAM_GROUPS-1:0] ramCsN
);

  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int ROM_AW    = 11;
  localparam int RAM_AW    = ROM_AW - 1;
  localparam int ROM_BANKS = 4;

  memStrobe_t strobes;

  memsys_decode #(
    .ADDR_W(ADDR_W), .ROM_AW(ROM_AW),
    .ROM_BANKS(ROM_BANKS), .RAM_GROUPS(RAM_GROUPS)
  ) u_decode (
    .addr(addr), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .romCsN(romCsN), .ramCsN(ramCsN), .strobes(strobes)
  );

  memsys_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW),
    .ROM_BANKS(ROM_BANKS), .RAM_GROUPS(RAM_GROUPS)
  ) u_store (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .romCsN(romCsN), .ramCsN(ramCsN), .strobes(strobes),
    .readData(readData), .busErr(busErr)
  );

  // R8: never two selects low at once
  a_r8_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~{romCsN, ramCsN}) <= 1);

  // R6: high address bits switch every select off
  a_r6_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    (|addr[15:14]) |-> (&romCsN && &ramCsN));

  // R6: a read that selects nothing yields zero and an error
  a_r6_miss_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && &{romCsN, ramCsN}) |=> (readData == 8'h00 && busErr));

  // R7: writing below 2000H is flagged
  a_r7_rom_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && addr[15:13] == 3'b000) |=> busErr);

endmodule

// File: tb/sim_banked_mem_sys.sv
module sim_banked_mem_sys;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = 16'hFFFF;
  logic [7:0]  wrData = 8'h00;
  logic        rdStrobe = 1'b0;
  logic        wrStrobe = 1'b0;

  logic [7:0]  readData, readData1;
  logic        busErr, busErr1;
  logic [3:0]  romCsN, romCsN1;
  logic [3:0]  ramCsN;
  logic [7:0]  ramCsN1;

  always #2.5 clk = ~clk;  // 200 MHz

  banked_mem_sys #(.RAM_GROUPS(4)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .readData(readData), .busErr(busErr), .romCsN(romCsN), .ramCsN(ramCsN));

  banked_mem_sys #(.RAM_GROUPS(8)) u1 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .readData(readData1), .busErr(busErr1), .romCsN(romCsN1), .ramCsN(ramCsN1));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // scoreboard queues
  int        dueQ[$];
  logic [7:0] datQ[$];
  logic      errQ[$];
  string     tagQ[$];

  logic [7:0] ramModel [int];
  logic [7:0] lastRd = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] romByte(input logic [15:0] a);
    logic [7:0] hi;
    hi = 8'(a >> 8) & 8'h1F;
    return (a & 16'h00FF) ^ 16'(hi);
  endfunction

  function automatic bit inRom(input logic [15:0] a);
    return a < 16'h2000;
  endfunction

  function automatic bit inRam(input logic [15:0] a, input int groups);
    return (a >= 16'h2000) && (int'(a) < 32'h2000 + groups * 32'h400);
  endfunction

  // monitor: compares registered outputs one clock after each access
  always @(negedge clk) begin
    while (dueQ.size() > 0 && dueQ[0] <= cyc) begin
      void'(dueQ.pop_front());
      begin
        logic [7:0] d;
        logic e;
        string t;
        d = datQ.pop_front();
        e = errQ.pop_front();
        t = tagQ.pop_front();
        chk(readData == d, t, "readData", readData, d);
        chk(busErr == e, t, "busErr", busErr, e);
      end
    end
  end

  task automatic access(input logic [15:0] a, input bit rd, input bit wr,
                        input logic [7:0] d, input string tag);
    logic [3:0] expRom;
    logic [3:0] expRam;
    logic [7:0] expD;
    logic       expE;
    bit         hit;
    addr = a; rdStrobe = rd; wrStrobe = wr; wrData = d;
    #1;
    // select checks (R1, R3, R6, R8)
    expRom = 4'hF;
    expRam = 4'hF;
    if (inRom(a)) expRom[(a >> 11) & 3] = 1'b0;
    if (inRam(a, 4)) expRam[(a - 16'h2000) >> 10] = 1'b0;
    chk(romCsN == expRom, tag, "romCsN", romCsN, expRom);
    chk(ramCsN == expRam, tag, "ramCsN", ramCsN, expRam);
    chk($countones(~{romCsN, ramCsN}) <= 1, "R8", "selects low", $countones(~{romCsN, ramCsN}), 1);
    hit = inRom(a) || inRam(a, 4);
    expD = lastRd;
    if (rd) begin
      if (inRom(a)) expD = romByte(a);
      else if (inRam(a, 4)) expD = ramModel.exists(int'(a)) ? ramModel[int'(a)] : 8'h00;
      else expD = 8'h00;
      lastRd = expD;
    end
    if (wr && inRam(a, 4)) ramModel[int'(a)] = d;
    expE = (rd || wr) && (!hit || (wr && inRom(a)));
    dueQ.push_back(cyc + 1);
    datQ.push_back(expD);
    errQ.push_back(expE);
    tagQ.push_back(tag);
    @(negedge clk);
    rdStrobe = 1'b0;
    wrStrobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state; R6: high address disables all selects
    chk(readData == 8'h00, "R5", "reset readData", readData, 0);
    chk(busErr == 1'b0, "R5", "reset busErr", busErr, 0);
    chk(&{romCsN, ramCsN}, "R6", "selects at FFFFH", {romCsN, ramCsN}, 8'hFF);
    rstN = 1'b1;
    @(negedge clk);

    // R1, R2: ROM bank edges and contents
    access(16'h0000, 1, 0, 8'h00, "R1");
    access(16'h07FF, 1, 0, 8'h00, "R2");
    access(16'h0800, 1, 0, 8'h00, "R1");
    access(16'h1234, 1, 0, 8'h00, "R2");
    access(16'h1FFF, 1, 0, 8'h00, "R2");

    // R3, R4: RAM group edges, nibbles differing
    access(16'h2000, 0, 1, 8'hA5, "R4");
    access(16'h23FF, 0, 1, 8'h3C, "R3");
    access(16'h2400, 0, 1, 8'h5A, "R3");
    access(16'h2BCD, 0, 1, 8'hF0, "R3");
    access(16'h2C00, 0, 1, 8'h0F, "R3");
    access(16'h2FFF, 0, 1, 8'h81, "R4");
    access(16'h2000, 1, 0, 8'h00, "R4");
    access(16'h23FF, 1, 0, 8'h00, "R4");
    access(16'h2400, 1, 0, 8'h00, "R4");
    access(16'h2BCD, 1, 0, 8'h00, "R4");
    access(16'h2C00, 1, 0, 8'h00, "R4");
    access(16'h2FFF, 1, 0, 8'h00, "R4");

    // R5: idle and write-only cycles hold the read byte
    access(16'h1000, 0, 0, 8'h00, "R5");
    access(16'h2001, 0, 1, 8'h66, "R5");
    access(16'h2001, 1, 0, 8'h00, "R5");

    // R6: unmapped addresses
    access(16'h4000, 1, 0, 8'h00, "R6");
    access(16'hC123, 1, 0, 8'h00, "R6");
    access(16'h3000, 1, 0, 8'h00, "R6");
    access(16'h8000, 0, 1, 8'h55, "R6");

    // R7: ROM write ignored and flagged
    access(16'h0100, 0, 1, 8'h00, "R7");
    access(16'h0100, 1, 0, 8'h00, "R7");
    access(16'h1801, 0, 1, 8'hFF, "R7");
    access(16'h1801, 1, 0, 8'h00, "R7");

    // R10: read and write together return the old byte
    access(16'h2000, 1, 1, 8'h11, "R10");
    access(16'h2000, 1, 0, 8'h00, "R10");

    // R9: eight-group variant stores in the upper block
    access(16'h3C05, 0, 1, 8'h77, "R9");
    chk(busErr1 == 1'b0, "R9", "u1 busErr on write", busErr1, 0);
    chk(ramCsN1 == 8'h7F, "R9", "u1 ramCsN at 3C05H", ramCsN1, 8'h7F);
    chk(romCsN1 == 4'hF, "R9", "u1 romCsN at 3C05H", romCsN1, 4'hF);
    access(16'h3C05, 1, 0, 8'h00, "R6");
    chk(readData1 == 8'h77, "R9", "u1 readData", readData1, 8'h77);
    chk(busErr1 == 1'b0, "R9", "u1 busErr on read", busErr1, 0);
    access(16'h3000, 0, 1, 8'h9E, "R6");
    access(16'h3000, 1, 0, 8'h00, "R6");
    chk(readData1 == 8'h9E, "R9", "u1 readData 3000H", readData1, 8'h9E);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule